// File: doc/BRIEF.md
# Two-Level Device Address Translation Walker

This block turns a device-side address issued on behalf of one of several streams into a physical address. Each stream has a 2-bit control word and a 32-bit table-base word, supplied as flat configuration vectors. A request names the stream, carries a wide address (of which only the low 36 bits matter) and a direction bit. The walker checks the stream's mode first. A bypass stream returns the address unchanged. A translating stream fetches one 64-bit entry from a first-level table and one from a second-level table over a memory read request/response channel, then either produces a physical address with an uncacheable attribute or reports a fault code.

Pages are 16 KiB. Each table holds 2048 eight-byte entries and fills exactly one page, so an entry address is a table frame number followed by an 11-bit index and three zero bits. The walker serves one translation at a time. Every data interface uses valid/ready. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. A memory read is issued when `mem_req_valid` and `mem_req_ready` are both high, and its data is taken when `mem_rsp_valid` and `mem_rsp_ready` are both high. A result is consumed when `rsp_valid` and `rsp_ready` are both high. While it is stalled, any offered request or result holds all of its fields.

Top module: `iova_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. `req_ready` is 1 only when no translation is in flight. It falls in the cycle after a request is accepted and rises in the cycle after its result is consumed.
- R2: Request address bits above bit 35 have no effect on any memory read address or on any result.
- R3: Control value 2'b10 (bit 1 = bypass, bit 0 = translate) is bypass. The result is code 0, `rsp_paddr` is address bits 35:0 zero-extended, uncacheable is 0, and no memory read is issued.
- R4: Control value 2'b00 or 2'b11 gives code 1 (bad mode) with no memory read.
- R5: In translate mode (2'b01), a base word with bit 0 clear gives code 2 (no table pointer) with no memory read.
- R6: The first read address is {base[29:2], addr[35:25], 3'b000}.
- R7: A first-level entry with bit 0 clear gives code 3 (no second-level table). Otherwise the second read address is {entry[37:10], addr[24:14], 3'b000}.
- R8: A leaf with bit 0 clear gives code 4 (no leaf). Every fault result carries `rsp_paddr` = 0 and uncacheable = 0.
- R9: A write to a leaf with bit 2 set gives code 6. A read from a leaf with bit 3 set gives code 5. The protection bit for the other direction has no effect.
- R10: A valid leaf that permits the access gives code 0, `rsp_paddr` = {leaf[37:10], addr[13:0]} and uncacheable = leaf bit 1.
- R11: A result held with `rsp_ready` low, and a memory read held with `mem_req_ready` low, keep all of their fields unchanged until accepted.
- R12: Stream s uses control bits [2s+1:2s] and base bits [32s+31:32s] of the configuration vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 2*NUM_STREAMS | Per-stream control words |
| cfg_base | input | 32*NUM_STREAMS | Per-stream table-base words |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted |
| req_stream | input | SID_W | Stream number |
| req_addr | input | IN_ADDR_W | Device address (low 36 bits used) |
| req_write | input | 1 | 1 = write access, 0 = read |
| mem_req_valid | output | 1 | Entry read offered |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 42 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result offered |
| rsp_ready | input | 1 | Consumer accepts result |
| rsp_code | output | 3 | 0 ok, 1 bad mode, 2 no pointer, 3 no table, 4 no leaf, 5 read fault, 6 write fault |
| rsp_paddr | output | 42 | Physical address (0 on fault) |
| rsp_uncached | output | 1 | Leaf uncacheable attribute |

## Verification
The bench builds the walker with the defaults: sixteen streams and a 64-bit request address. With sixteen streams, every slot of the flat configuration vectors can be reached, including the slots that select a bad mode, a missing base and a second table tree. The 64-bit address leaves 28 upper bits that the bench fills with random values to exercise truncation. Table entries are placed at index 0 and index 2047 at both levels, and at the all-ones frame number, so the extreme concatenations of the entry addresses and of the result address are covered.

// File: rtl/iova_walker_pkg.sv
package iova_walker_pkg;
  localparam int PAGE_BITS = 14;
  localparam int IDX_W = PAGE_BITS - 3;
  localparam int LEVELS = 2;
  localparam int VA_W = PAGE_BITS + LEVELS * IDX_W;
  localparam int FRAME_W = 28;
  localparam int PA_W = FRAME_W + PAGE_BITS;
  localparam int ENTRY_W = 64;
  localparam int BASE_W = 32;

  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_NOCACHE_BIT = 1;
  localparam int ENT_NOWR_BIT = 2;
  localparam int ENT_NORD_BIT = 3;
  localparam int ENT_FRAME_LSB = 10;
  localparam int BASE_VALID_BIT = 0;
  localparam int BASE_FRAME_LSB = 2;
  localparam int CTRL_XLAT_BIT = 0;
  localparam int CTRL_PASS_BIT = 1;

  typedef enum logic [1:0] {
    MODE_XLAT,
    MODE_PASS,
    MODE_BAD
  } xlat_mode_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_MODE     = 3'd1,
    FLT_NO_BASE  = 3'd2,
    FLT_NO_TABLE = 3'd3,
    FLT_NO_LEAF  = 3'd4,
    FLT_READ     = 3'd5,
    FLT_WRITE    = 3'd6
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_RESP
  } walk_state_e;

  // Index field of a given level; level 0 is the topmost table.
  function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va,
                                                   input int unsigned lvl);
    return va[PAGE_BITS + (LEVELS - 1 - lvl) * IDX_W +: IDX_W];
  endfunction

  // A table fills one page, so frame, index and byte lane concatenate.
  function automatic logic [PA_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                 input logic [IDX_W-1:0] idx);
    return {frame, idx, 3'b000};
  endfunction
endpackage

// File: rtl/iova_cfg_select.sv
module iova_cfg_select
  import iova_walker_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int SID_W = 4
) (
  input  logic [2*NUM_STREAMS-1:0]      cfg_ctrl,
  input  logic [BASE_W*NUM_STREAMS-1:0] cfg_base,
  input  logic [SID_W-1:0]              sid,
  output xlat_mode_e                    mode,
  output logic                          base_valid,
  output logic [FRAME_W-1:0]            base_frame
);
  localparam int SLOTS = 1 << SID_W;

  logic [1:0]        ctrl_tab [SLOTS];
  logic [BASE_W-1:0] base_tab [SLOTS];

  // Slots past the configured stream count read as "neither bit set".
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_STREAMS) begin : g_live
      assign ctrl_tab[s] = cfg_ctrl[2*s +: 2];
      assign base_tab[s] = cfg_base[BASE_W*s +: BASE_W];
    end else begin : g_absent
      assign ctrl_tab[s] = '0;
      assign base_tab[s] = '0;
    end
  end

  logic [1:0]        sel_ctrl;
  logic [BASE_W-1:0] sel_base;
  assign sel_ctrl = ctrl_tab[sid];
  assign sel_base = base_tab[sid];

  always_comb begin
    if (sel_ctrl[CTRL_PASS_BIT] && !sel_ctrl[CTRL_XLAT_BIT])      mode = MODE_PASS;
    else if (sel_ctrl[CTRL_XLAT_BIT] && !sel_ctrl[CTRL_PASS_BIT]) mode = MODE_XLAT;
    else                                                          mode = MODE_BAD;
  end

  assign base_valid = sel_base[BASE_VALID_BIT];
  assign base_frame = sel_base[BASE_FRAME_LSB +: FRAME_W];

  logic unused_base;
  assign unused_base = ^{sel_base[BASE_W-1:BASE_FRAME_LSB+FRAME_W],
                         sel_base[BASE_FRAME_LSB-1:BASE_VALID_BIT+1]};
endmodule

// File: rtl/iova_pte_decode.sv
module iova_pte_decode
  import iova_walker_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  output logic               ent_valid,
  output logic               ent_uncached,
  output logic               ent_deny,
  output logic [FRAME_W-1:0] ent_frame
);
  assign ent_valid    = entry[ENT_VALID_BIT];
  assign ent_uncached = entry[ENT_NOCACHE_BIT];
  assign ent_frame    = entry[ENT_FRAME_LSB +: FRAME_W];
  // Only the protection bit of the access direction matters.
  assign ent_deny     = is_write ? entry[ENT_NOWR_BIT] : entry[ENT_NORD_BIT];

  logic unused_ent;
  assign unused_ent = ^{entry[ENTRY_W-1:ENT_FRAME_LSB+FRAME_W],
                        entry[ENT_FRAME_LSB-1:ENT_NORD_BIT+1]};
endmodule

// File: rtl/iova_walk_fsm.sv
module iova_walk_fsm
  import iova_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  input  xlat_mode_e         sel_mode,
  input  logic               sel_base_valid,
  input  logic [FRAME_W-1:0] sel_base_frame,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic               ent_valid,
  input  logic               ent_uncached,
  input  logic               ent_deny,
  input  logic [FRAME_W-1:0] ent_frame,
  output logic               write_q,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output fault_e             rsp_code,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_uncached
);
  walk_state_e       state;
  logic [VA_W-1:0]   va_q;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_rsp_ready = (state == ST_L1_WAIT) || (state == ST_L2_WAIT);
  assign rsp_valid     = (state == ST_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      write_q      <= 1'b0;
      mem_req_addr <= '0;
      rsp_code     <= FLT_NONE;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q         <= req_va;
            write_q      <= req_write;
            rsp_code     <= FLT_NONE;
            rsp_paddr    <= '0;
            rsp_uncached <= 1'b0;
            unique case (sel_mode)
              MODE_PASS: begin
                rsp_paddr <= PA_W'(req_va);
                state     <= ST_RESP;
              end
              MODE_XLAT: begin
                if (sel_base_valid) begin
                  mem_req_addr <= entry_addr(sel_base_frame, level_index(req_va, 0));
                  state        <= ST_L1_REQ;
                end else begin
                  rsp_code <= FLT_NO_BASE;
                  state    <= ST_RESP;
                end
              end
              default: begin
                rsp_code <= FLT_MODE;
                state    <= ST_RESP;
              end
            endcase
          end
        end
        ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (ent_valid) begin
              mem_req_addr <= entry_addr(ent_frame, level_index(va_q, 1));
              state        <= ST_L2_REQ;
            end else begin
              rsp_code <= FLT_NO_TABLE;
              state    <= ST_RESP;
            end
          end
        end
        ST_L2_REQ: if (mem_req_ready) state <= ST_L2_WAIT;
        ST_L2_WAIT: begin
          if (mem_rsp_valid) begin
            state <= ST_RESP;
            if (!ent_valid) begin
              rsp_code <= FLT_NO_LEAF;
            end else if (ent_deny) begin
              rsp_code <= write_q ? FLT_WRITE : FLT_READ;
            end else begin
              rsp_paddr    <= {ent_frame, va_q[PAGE_BITS-1:0]};
              rsp_uncached <= ent_uncached;
            end
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_va;
  assign unused_va = ^va_q[VA_W-1 -: IDX_W];

  // R1: an accepted request closes the door until its result is consumed
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11: stalled result holds its fields
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)
                                   && $stable(rsp_paddr) && $stable(rsp_uncached)));

  // R11: stalled memory read holds its address
  assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: bypass answers in the next cycle without touching memory
  assert_pass_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && sel_mode == MODE_PASS) |=> (rsp_valid && rsp_code == FLT_NONE));

  // R4: a bad mode answers with code 1 without touching memory
  assert_bad_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && sel_mode == MODE_BAD) |=> (rsp_valid && rsp_code == FLT_MODE));

  // R10: a successful result keeps the page offset of the request
  assert_offset_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == FLT_NONE) |-> (rsp_paddr[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0]));

  // R8: faults carry no address and no attribute
  assert_fault_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != FLT_NONE) |-> (rsp_paddr == '0 && !rsp_uncached));

  // R1: the walker never offers a read while waiting for one
  assert_single_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_rsp_ready);
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iova_walker_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int IN_ADDR_W = 64,
  localparam int SID_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2*NUM_STREAMS-1:0]      cfg_ctrl,
  input  logic [BASE_W*NUM_STREAMS-1:0] cfg_base,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SID_W-1:0]              req_stream,
  input  logic [IN_ADDR_W-1:0]          req_addr,
  input  logic                          req_write,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [PA_W-1:0]               mem_req_addr,
  input  logic                          mem_rsp_valid,
  output logic                          mem_rsp_ready,
  input  logic [ENTRY_W-1:0]            mem_rsp_data,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [2:0]                    rsp_code,
  output logic [PA_W-1:0]               rsp_paddr,
  output logic                          rsp_uncached
);
  // Upper address bits are dropped before anything looks at the address.
  logic [VA_W-1:0] va;
  assign va = req_addr[VA_W-1:0];

  logic unused_addr_hi;
  assign unused_addr_hi = ^req_addr[IN_ADDR_W-1:VA_W];

  xlat_mode_e         sel_mode;
  logic               sel_base_valid;
  logic [FRAME_W-1:0] sel_base_frame;

  iova_cfg_select #(
    .NUM_STREAMS(NUM_STREAMS),
    .SID_W      (SID_W)
  ) u_cfg (
    .cfg_ctrl  (cfg_ctrl),
    .cfg_base  (cfg_base),
    .sid       (req_stream),
    .mode      (sel_mode),
    .base_valid(sel_base_valid),
    .base_frame(sel_base_frame)
  );

  logic               write_q;
  logic               ent_valid;
  logic               ent_uncached;
  logic               ent_deny;
  logic [FRAME_W-1:0] ent_frame;

  iova_pte_decode u_pte (
    .entry       (mem_rsp_data),
    .is_write    (write_q),
    .ent_valid   (ent_valid),
    .ent_uncached(ent_uncached),
    .ent_deny    (ent_deny),
    .ent_frame   (ent_frame)
  );

  fault_e code_w;
  assign rsp_code = code_w;

  iova_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (va),
    .req_write     (req_write),
    .sel_mode      (sel_mode),
    .sel_base_valid(sel_base_valid),
    .sel_base_frame(sel_base_frame),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .ent_valid     (ent_valid),
    .ent_uncached  (ent_uncached),
    .ent_deny      (ent_deny),
    .ent_frame     (ent_frame),
    .write_q       (write_q),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_code      (code_w),
    .rsp_paddr     (rsp_paddr),
    .rsp_uncached  (rsp_uncached)
  );
endmodule

// File: tb/test_iova_walker.sv
module test_iova_walker;
  localparam int NS = 16;
  localparam int IAW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*NS-1:0]  cfg_ctrl = '0;
  logic [32*NS-1:0] cfg_base = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [3:0]    req_stream = '0;
  logic [IAW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [41:0]   mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic [63:0]   mem_rsp_data = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [2:0]    rsp_code;
  logic [41:0]   rsp_paddr;
  logic          rsp_uncached;

  iova_walker #(.NUM_STREAMS(NS), .IN_ADDR_W(IAW)) i_iova_walker (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_stream(req_stream),
    .req_addr(req_addr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached));

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    int          code;
    logic [41:0] pa;
    bit          uc;
    string       tag;
  } exp_t;

  logic [63:0] mem_tbl [logic [41:0]];
  exp_t        exp_q [$];
  logic [41:0] exp_maddr [$];
  logic [41:0] pend_q [$];
  int vectors = 0;
  int errors = 0;
  int outstanding = 0;
  int bp = 0;
  bit finished = 0;
  bit reported = 0;
  string focus = "";
  bit stall_r = 0;
  logic [2:0] stall_code;
  logic [41:0] stall_pa;
  bit stall_uc;
  bit mstall = 0;
  logic [41:0] mstall_addr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", focus, tag, act, expv);
    end
  endtask

  function automatic logic [63:0] rd(input logic [41:0] a);
    return mem_tbl.exists(a) ? mem_tbl[a] : 64'h0;
  endfunction

  function automatic logic [41:0] ea(input logic [27:0] frame, input logic [10:0] idx);
    return {frame, idx, 3'b000};
  endfunction

  // Entry with junk in the bits the walker must ignore.
  function automatic logic [63:0] ent(input logic [27:0] frame, input bit uc,
                                      input bit nowr, input bit nord);
    logic [63:0] e;
    e = '0;
    e[63:38] = 26'h2AA_AAAA;
    e[37:10] = frame;
    e[9:4]   = 6'h15;
    e[3:0]   = {nord, nowr, uc, 1'b1};
    return e;
  endfunction

  function automatic logic [63:0] mkva(input logic [10:0] l1, input logic [10:0] l2,
                                       input logic [13:0] off);
    return {28'h0, l1, l2, off};
  endfunction

  // Behavioural reference: decides result and expected reads from the requirements.
  function automatic exp_t ref_walk(input int sid, input logic [63:0] a, input bit wr);
    exp_t r;
    logic [35:0] v;
    logic [1:0] c;
    logic [31:0] b;
    logic [63:0] e1;
    logic [63:0] e2;
    logic [41:0] ad;
    v = a[35:0];  // R2 truncation
    c = cfg_ctrl[sid*2 +: 2];  // R12 slot selection
    b = cfg_base[sid*32 +: 32];
    r.code = 0; r.pa = '0; r.uc = 0; r.tag = "R10";
    if (c == 2'b10) begin r.pa = {6'h0, v}; r.tag = "R3"; return r; end
    if (c != 2'b01) begin r.code = 1; r.tag = "R4"; return r; end
    if (!b[0]) begin r.code = 2; r.tag = "R5"; return r; end
    ad = {b[29:2], v[35:25], 3'b000};  // R6
    exp_maddr.push_back(ad);
    e1 = rd(ad);
    if (!e1[0]) begin r.code = 3; r.tag = "R7"; return r; end
    ad = {e1[37:10], v[24:14], 3'b000};  // R7
    exp_maddr.push_back(ad);
    e2 = rd(ad);
    if (!e2[0]) begin r.code = 4; r.tag = "R8"; return r; end
    if (wr && e2[2]) begin r.code = 6; r.tag = "R9"; return r; end
    if (!wr && e2[3]) begin r.code = 5; r.tag = "R9"; return r; end
    r.pa = {e2[37:10], v[13:0]};
    r.uc = e2[1];
    return r;
  endfunction

  // Edge monitor: handshakes, memory model, back-pressure drivers.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_req_ready <= 1'b0;
      rsp_ready     <= 1'b0;
      stall_r = 0;
      mstall  = 0;
    end else begin
      if (req_valid && req_ready) begin
        outstanding++;
        exp_q.push_back(ref_walk(int'(req_stream), req_addr, req_write));
      end
      if (mem_req_valid && mem_req_ready) begin
        if (exp_maddr.size() == 0) begin
          chk(1'b0, "R6/R7 unexpected read", 64'(mem_req_addr), 64'h0);
        end else begin
          chk(mem_req_addr == exp_maddr[0], "R6/R7 read address",
              64'(mem_req_addr), 64'(exp_maddr[0]));
          void'(exp_maddr.pop_front());
        end
        pend_q.push_back(mem_req_addr);
      end
      if (mem_rsp_valid && mem_rsp_ready) begin
        mem_rsp_valid <= 1'b0;
      end else if (!mem_rsp_valid && pend_q.size() > 0 && (bp == 0 || $urandom % 3 != 0)) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(pend_q.pop_front());
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected result", 64'(rsp_code), 64'h0);
        end else begin
          chk(rsp_code == 3'(exp_q[0].code), {exp_q[0].tag, " code"},
              64'(rsp_code), 64'(exp_q[0].code));
          chk(rsp_paddr == exp_q[0].pa, {exp_q[0].tag, " paddr"},
              64'(rsp_paddr), 64'(exp_q[0].pa));
          chk(rsp_uncached == exp_q[0].uc, {exp_q[0].tag, " uncached"},
              64'(rsp_uncached), 64'(exp_q[0].uc));
          chk(exp_maddr.size() == 0, {exp_q[0].tag, " read count"},
              64'(exp_maddr.size()), 64'h0);
          void'(exp_q.pop_front());
        end
        outstanding--;
      end
      stall_r = rsp_valid && !rsp_ready;
      stall_code = rsp_code; stall_pa = rsp_paddr; stall_uc = rsp_uncached;
      mstall = mem_req_valid && !mem_req_ready;
      mstall_addr = mem_req_addr;
      mem_req_ready <= (bp == 0) ? 1'b1 : ($urandom % 3 != 0);
      rsp_ready     <= (bp == 0) ? 1'b1 : ($urandom % 4 == 0);
    end
  end

  // Cycle comparison against the reference state, away from the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (outstanding == 0), "R1 ready vs in-flight",
          64'(req_ready), 64'(outstanding == 0));
      if (stall_r) begin
        chk(rsp_valid && rsp_code == stall_code && rsp_paddr == stall_pa
            && rsp_uncached == stall_uc, "R11 result hold",
            {19'h0, rsp_valid, rsp_code, rsp_paddr}, {20'h1, stall_code, stall_pa});
      end
      if (mstall) begin
        chk(mem_req_valid && mem_req_addr == mstall_addr, "R11 read hold",
            {21'h0, mem_req_valid, mem_req_addr}, {22'h1, mstall_addr});
      end
    end
  end

  task automatic send(input int sid, input logic [63:0] a, input bit wr);
    req_stream <= 4'(sid);
    req_addr   <= a;
    req_write  <= wr;
    req_valid  <= 1'b1;
    do @(posedge clk); while (!req_ready);
    req_valid  <= 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // Stream slots (R12): 0 translate, 1 bypass, 2 none, 3 both,
    // 4 translate without base, 5 translate on a second tree, 6..15 none.
    cfg_ctrl[0*2 +: 2] = 2'b01; cfg_base[0*32 +: 32] = {2'b11, 28'h0000100, 2'b01};
    cfg_ctrl[1*2 +: 2] = 2'b10; cfg_base[1*32 +: 32] = {2'b00, 28'h0000100, 2'b01};
    cfg_ctrl[2*2 +: 2] = 2'b00; cfg_base[2*32 +: 32] = {2'b00, 28'h0000100, 2'b01};
    cfg_ctrl[3*2 +: 2] = 2'b11; cfg_base[3*32 +: 32] = {2'b00, 28'h0000100, 2'b01};
    cfg_ctrl[4*2 +: 2] = 2'b01; cfg_base[4*32 +: 32] = {2'b00, 28'h0000100, 2'b10};
    cfg_ctrl[5*2 +: 2] = 2'b01; cfg_base[5*32 +: 32] = {2'b00, 28'h0002345, 2'b01};

    mem_tbl[ea(28'h100, 11'd3)]     = ent(28'h200, 0, 0, 0);
    mem_tbl[ea(28'h100, 11'h7FF)]   = ent(28'h300, 0, 0, 0);
    mem_tbl[ea(28'h100, 11'd0)]     = ent(28'h500, 0, 1, 1);
    mem_tbl[ea(28'h200, 11'd0)]     = ent(28'h00ABCDE, 0, 0, 0);
    mem_tbl[ea(28'h200, 11'd1)]     = ent(28'h0012345, 1, 0, 0);
    mem_tbl[ea(28'h200, 11'd2)]     = ent(28'h0000777, 0, 1, 0);
    mem_tbl[ea(28'h200, 11'd3)]     = ent(28'h0000888, 1, 0, 1);
    mem_tbl[ea(28'h200, 11'h7FF)]   = ent(28'hFFFFFFF, 0, 0, 0);
    mem_tbl[ea(28'h300, 11'h7FF)]   = ent(28'h1234567, 1, 0, 0);
    mem_tbl[ea(28'h500, 11'd0)]     = ent(28'h0000999, 0, 0, 0);
    mem_tbl[ea(28'h2345, 11'd3)]    = ent(28'h400, 0, 0, 0);
    mem_tbl[ea(28'h400, 11'd0)]     = ent(28'h0055555, 0, 0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    focus = "reset";
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'h1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", 64'(mem_req_valid), 64'h0);
    rst_n = 1'b1;
    @(posedge clk);

    focus = "R10";
    send(0, mkva(11'd3, 11'd0, 14'h1234), 0);
    send(0, mkva(11'd3, 11'd1, 14'h0ABC), 1);
    send(0, mkva(11'd3, 11'h7FF, 14'h3FFF), 0);
    send(0, mkva(11'h7FF, 11'h7FF, 14'd1), 1);
    focus = "R9";
    send(0, mkva(11'd3, 11'd2, 14'd5), 1);
    send(0, mkva(11'd3, 11'd2, 14'd5), 0);
    send(0, mkva(11'd3, 11'd3, 14'd7), 0);
    send(0, mkva(11'd3, 11'd3, 14'd7), 1);
    focus = "R8";
    send(0, mkva(11'd3, 11'd4, 14'd0), 0);
    focus = "R7";
    send(0, mkva(11'd5, 11'd0, 14'd0), 0);
    send(0, mkva(11'd0, 11'd0, 14'd9), 1);  // protection bits on a table entry are ignored
    focus = "R2";
    send(1, 64'hFFFF_F123_4567_89AB, 1);
    send(0, 64'hABCD_0000_0000_0000 | mkva(11'd3, 11'd0, 14'h22), 0);
    focus = "R4";
    send(2, mkva(11'd3, 11'd0, 14'd0), 0);
    send(3, mkva(11'd3, 11'd0, 14'd0), 1);
    send(6, mkva(11'd3, 11'd0, 14'd0), 0);
    focus = "R5";
    send(4, mkva(11'd3, 11'd0, 14'd0), 0);
    focus = "R12";
    send(5, mkva(11'd3, 11'd0, 14'h10), 0);
    send(5, mkva(11'h7FF, 11'd0, 14'h10), 0);

    focus = "R11";
    bp = 1;
    for (int n = 0; n < 400; n++) begin
      int sid;
      logic [10:0] l1;
      logic [10:0] l2;
      logic [63:0] a;
      sid = $urandom % 8;
      case ($urandom % 4)
        0: l1 = 11'd3;
        1: l1 = 11'd5;
        2: l1 = 11'h7FF;
        default: l1 = 11'd0;
      endcase
      case ($urandom % 6)
        0: l2 = 11'd0;
        1: l2 = 11'd1;
        2: l2 = 11'd2;
        3: l2 = 11'd3;
        4: l2 = 11'd4;
        default: l2 = 11'h7FF;
      endcase
      a = mkva(l1, l2, 14'($urandom));
      a[63:36] = 28'($urandom);
      send(sid, a, 1'($urandom));
    end
    while (outstanding != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    focus = "end";
    chk(exp_q.size() == 0, "R1 drained", 64'(exp_q.size()), 64'h0);
    finished = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog act=hung exp=done");
      report();
    end
  end
endmodule